// File: doc/BRIEF.md
# Idle Request Acknowledge Handshake

This block is the module side of a power-manager idle handshake. A system power controller raises a synchronous idle request. The block answers with an idle acknowledge, following one of three policies chosen by a 2-bit idle-mode field:

- **No-idle** ignores the request.
- **Force-idle** grants it at once.
- **Smart-idle** grants it only once the module has gone quiet. For a master, quiet means no channel has a pending transfer. For a slave, it means the external select is released. In both cases no interrupt or DMA request line may be active.

While the request is high, any host access gets an error response. While an acknowledge granted under the smart policy is held, two outputs tell the power controller which clocks it may stop. Each is gated by its own clock-activity bit.

The acknowledge is a single register. Once granted, it stays high until the request drops, whatever happens on the busy lines or the mode field in the meantime. The block is never in the normal state and the idle state at once.

Top module: `idle_handshake`

## Requirements
- R1: After reset, idle_ack, host_err, host_clk_off and ser_clk_off are all low.
- R2: With idle_mode = 2'b00 (force idle), a clock edge that sees idle_req high sets idle_ack on that edge, whatever the busy inputs are.
- R3: With idle_mode = 2'b01 (no idle), a clock edge that sees idle_ack low leaves idle_ack low, whatever idle_req is.
- R4: With idle_mode = 2'b10 (smart idle) and is_master low, an edge that sees idle_req high sets idle_ack only if slave_sel, irq and every dma_req bit are all low. Otherwise idle_ack stays low.
- R5: In smart idle with is_master high, xfer_pending takes the place of slave_sel in the quiet condition. slave_sel is then ignored.
- R6: idle_mode = 2'b11 behaves exactly like smart idle.
- R7: Once idle_ack is high, it stays high on every edge that sees idle_req high, even if busy inputs or idle_mode change.
- R8: An edge that sees idle_req low clears idle_ack.
- R9: host_err is high in the cycle after an edge that saw host_acc and idle_req both high, and low after any other edge.
- R10: host_clk_off is high only while idle_ack is high, that acknowledge was granted under a smart mode, and clk_act[0] is high. ser_clk_off follows the same rule with clk_act[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Synchronous idle request from the power controller |
| idle_mode | input | 2 | Policy: 00 force, 01 none, 10/11 smart |
| clk_act | input | 2 | Bit 0 allows host clock stop, bit 1 allows serial clock stop |
| is_master | input | 1 | Module operates as serial master |
| xfer_pending | input | 1 | Master: some channel has a transfer pending |
| slave_sel | input | 1 | Slave: external select is active |
| irq | input | 1 | Interrupt line is active |
| dma_req | input | NDMA | DMA request lines |
| host_acc | input | 1 | Host access strobe |
| idle_ack | output | 1 | Idle acknowledge |
| host_err | output | 1 | Error response for the access of the previous cycle |
| host_clk_off | output | 1 | Host clock may be stopped |
| ser_clk_off | output | 1 | Serial clock may be stopped |

## Verification
The bench goes after the following corner cases, each of which a faulty design would show at the ports:

- **Busy lines returning after a grant.** A design that re-evaluates the quiet condition every cycle would drop the acknowledge while the request is still high.
- **Single busy lines in smart mode.** One DMA bit, irq alone, or the select line alone each blocks the grant. A design that misses any of them would acknowledge while that line is active.
- **The wrong busy source for the role.** A design that uses the select line for a master, or ignores xfer_pending, would grant in the wrong cycle.
- **The reserved 11 encoding.** A design that decodes it as force or no-idle would grant, or refuse, independently of the busy lines.
- **Clock-stop indications in force mode.** A design that does not remember how the acknowledge was granted would raise them there.

// File: rtl/idle_handshake.sv
module idle_handshake #(
  parameter int NDMA = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_req,
  input  logic [1:0]      idle_mode,
  input  logic [1:0]      clk_act,
  input  logic            is_master,
  input  logic            xfer_pending,
  input  logic            slave_sel,
  input  logic            irq,
  input  logic [NDMA-1:0] dma_req,
  input  logic            host_acc,
  output logic            idle_ack,
  output logic            host_err,
  output logic            host_clk_off,
  output logic            ser_clk_off
);

  localparam logic [1:0] MODE_FORCE = 2'b00;
  localparam logic [1:0] MODE_NONE  = 2'b01;

  logic ack_q, smart_q, err_q;
  logic busy, quiet, smart_mode, grant;

  assign busy       = is_master ? xfer_pending : slave_sel;
  assign quiet      = !busy && !irq && !(|dma_req);
  assign smart_mode = idle_mode[1];
  assign grant      = (idle_mode == MODE_FORCE) ||
                      (smart_mode && quiet && idle_mode != MODE_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      smart_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= host_acc && idle_req;
      if (!idle_req) begin
        ack_q   <= 1'b0;
        smart_q <= 1'b0;
      end else if (!ack_q && grant) begin
        ack_q   <= 1'b1;
        smart_q <= smart_mode;
      end
    end
  end

  assign idle_ack     = ack_q;
  assign host_err     = err_q;
  assign host_clk_off = ack_q && smart_q && clk_act[0];
  assign ser_clk_off  = ack_q && smart_q && clk_act[1];

endmodule

module idle_handshake_chk #(
  parameter int NDMA = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            idle_req,
  input logic [1:0]      idle_mode,
  input logic [1:0]      clk_act,
  input logic            is_master,
  input logic            xfer_pending,
  input logic            slave_sel,
  input logic            irq,
  input logic [NDMA-1:0] dma_req,
  input logic            host_acc,
  input logic            idle_ack,
  input logic            host_err,
  input logic            host_clk_off,
  input logic            ser_clk_off
);

  // R2
  force_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && idle_mode == 2'b00) |=> idle_ack);

  // R3
  no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_ack && idle_mode == 2'b01) |=> !idle_ack);

  // R4
  smart_slave_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_ack && idle_mode[1] && !is_master && (slave_sel || irq || (|dma_req)))
    |=> !idle_ack);

  // R5
  smart_master_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_ack && idle_mode[1] && is_master && xfer_pending) |=> !idle_ack);

  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ack && idle_req) |=> idle_ack);

  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> !idle_ack);

  // R9
  err_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc && idle_req) |=> host_err);

  // R10
  host_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_clk_off |-> (idle_ack && clk_act[0]));

  // R10
  ser_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk_off |-> (idle_ack && clk_act[1]));

endmodule

bind idle_handshake idle_handshake_chk #(.NDMA(NDMA)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_mode(idle_mode),
  .clk_act(clk_act), .is_master(is_master), .xfer_pending(xfer_pending),
  .slave_sel(slave_sel), .irq(irq), .dma_req(dma_req), .host_acc(host_acc),
  .idle_ack(idle_ack), .host_err(host_err), .host_clk_off(host_clk_off),
  .ser_clk_off(ser_clk_off)
);

// File: tb/idle_handshake_tb.sv
module idle_handshake_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDMA = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic idle_req = 0, is_master = 0, xfer_pending = 0, slave_sel = 0, irq = 0, host_acc = 0;
  logic [1:0] idle_mode = 2'b01, clk_act = 2'b00;
  logic [NDMA-1:0] dma_req = '0;
  logic idle_ack, host_err, host_clk_off, ser_clk_off;

  int checks = 0, errors = 0;
  logic m_ack = 0, m_smart = 0, m_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_handshake #(.NDMA(NDMA)) u_dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_mode(idle_mode),
    .clk_act(clk_act), .is_master(is_master), .xfer_pending(xfer_pending),
    .slave_sel(slave_sel), .irq(irq), .dma_req(dma_req), .host_acc(host_acc),
    .idle_ack(idle_ack), .host_err(host_err), .host_clk_off(host_clk_off),
    .ser_clk_off(ser_clk_off)
  );

  function automatic logic quiet_f();
    return !(is_master ? xfer_pending : slave_sel) && !irq && !(|dma_req);
  endfunction

  function automatic logic grant_f();
    if (idle_mode == 2'b00) return 1'b1;
    if (idle_mode == 2'b01) return 1'b0;
    return quiet_f();
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    m_err = host_acc && idle_req;
    if (!idle_req) begin m_ack = 0; m_smart = 0; end
    else if (!m_ack && grant_f()) begin m_ack = 1; m_smart = idle_mode[1]; end
    #1;
  endtask

  task automatic check_all(string tag);
    chk({tag, " R7/R8 idle_ack"}, idle_ack, m_ack);
    chk({tag, " R9 host_err"}, host_err, m_err);
    chk({tag, " R10 host_clk_off"}, host_clk_off, m_ack && m_smart && clk_act[0]);
    chk({tag, " R10 ser_clk_off"}, ser_clk_off, m_ack && m_smart && clk_act[1]);
  endtask

  task automatic drive_neg();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d1e));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 ack", idle_ack, 0); chk("R1 err", host_err, 0);
    chk("R1 hoff", host_clk_off, 0); chk("R1 soff", ser_clk_off, 0);
    rst_n = 1;

    // R3: no idle ignores request
    drive_neg(); idle_mode = 2'b01; idle_req = 1;
    repeat (3) step();
    chk("R3 no-idle ack", idle_ack, 0);

    // R9: access under request
    drive_neg(); host_acc = 1; step();
    chk("R9 err", host_err, 1);
    drive_neg(); host_acc = 0; step();
    chk("R9 err clears", host_err, 0);

    // R2: force with busy lines
    drive_neg(); idle_mode = 2'b00; slave_sel = 1; irq = 1; clk_act = 2'b11; step();
    chk("R2 force ack", idle_ack, 1);
    chk("R10 force no hoff", host_clk_off, 0);
    // R8
    drive_neg(); idle_req = 0; step();
    chk("R8 drop", idle_ack, 0);

    // R4: smart slave, single busy line blocks
    drive_neg(); idle_mode = 2'b10; irq = 0; slave_sel = 1; idle_req = 1; step();
    chk("R4 sel blocks", idle_ack, 0);
    drive_neg(); slave_sel = 0; dma_req = 2'b10; step();
    chk("R4 dma blocks", idle_ack, 0);
    drive_neg(); dma_req = 0; irq = 1; step();
    chk("R4 irq blocks", idle_ack, 0);
    drive_neg(); irq = 0; clk_act = 2'b01; step();
    chk("R4 quiet grants", idle_ack, 1);
    chk("R10 hoff", host_clk_off, 1); chk("R10 soff", ser_clk_off, 0);
    // R7: activity returns
    drive_neg(); slave_sel = 1; irq = 1; idle_mode = 2'b01; step();
    chk("R7 hold", idle_ack, 1);
    drive_neg(); idle_req = 0; irq = 0; step();
    chk("R8 drop2", idle_ack, 0);

    // R5: master uses xfer_pending, ignores sel
    drive_neg(); idle_mode = 2'b10; is_master = 1; xfer_pending = 1; slave_sel = 0; idle_req = 1; step();
    chk("R5 pending blocks", idle_ack, 0);
    drive_neg(); xfer_pending = 0; slave_sel = 1; step();
    chk("R5 sel ignored", idle_ack, 1);
    drive_neg(); idle_req = 0; step();

    // R6: reserved acts smart
    drive_neg(); idle_mode = 2'b11; is_master = 0; slave_sel = 1; idle_req = 1; clk_act = 2'b10; step();
    chk("R6 busy blocks", idle_ack, 0);
    drive_neg(); slave_sel = 0; step();
    chk("R6 grants", idle_ack, 1);
    chk("R6 R10 soff", ser_clk_off, 1);
    drive_neg(); idle_req = 0; step();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      drive_neg();
      if ($urandom_range(0, 7) == 0) idle_req = ~idle_req;
      if ($urandom_range(0, 15) == 0) idle_mode = 2'($urandom);
      clk_act = 2'($urandom); is_master = ($urandom_range(0, 31) == 0) ? ~is_master : is_master;
      xfer_pending = $urandom_range(0, 2) == 0; slave_sel = $urandom_range(0, 2) == 0;
      irq = $urandom_range(0, 5) == 0; dma_req = ($urandom_range(0, 3) == 0) ? NDMA'($urandom) : '0;
      host_acc = $urandom_range(0, 3) == 0;
      step();
      check_all("rand");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule